// File: doc/BRIEF.md
# Converter Parallel Bus Controller

This block sits on the host side of a 12-bit bidirectional parallel bus to a sigma-delta converter. The bus has an active-low chip select, an active-low read strobe and an active-low write strobe. The block owns the direction of the shared data lines. It drives them only while it writes a control word, and it leaves them floating at all other times. After reset it writes the control word once. It writes the word again whenever the system changes the standby, input-range or shared-pin setting, and whenever the system asks for a calibration.

When the converter signals new data with a falling edge on its active-low data-ready line, the block runs a read cycle. It captures the conversion word and presents it to the system with a one-cycle valid pulse. A busy flag covers the whole calibration, from the request until the converter reports fresh data.

One converter pin can work either as a data-valid output or as a sync input. When the control word puts that pin in sync mode, the block drives it. It idles the pin high and pulses it low for a set number of cycles when the system asks for a sync. When the pin is taken back out of sync mode, the block releases it only while it is driving it high. This means no rising edge can appear on the pin during the change.

Top module: `adc_par_ctrl`

## Requirements
- R1: While reset is asserted, chip select, read and write are all high, the data lines are released, busy and data-valid are low, and the shared pin is not driven.
- R2: After reset is released, exactly one control-word write takes place with the current settings, and no further write follows while the settings stay unchanged.
- R3: The control word has standby in bit 0 (1 = standby), the calibration start in bit 1, bipolar range in bit 2 (1 = bipolar, 0 = unipolar), and shared-pin sync mode in bit 3 (1 = sync input, 0 = data-valid output). Every other bit, including the test bit 9, is written as 0.
- R4: Any change of the standby, range or shared-pin setting produces a new write that carries the new values.
- R5: A calibration request sets bit 1 in the next control word written. Later writes clear bit 1 unless a new request has arrived.
- R6: The busy flag rises in the cycle after a calibration request. It stays high until the first data-ready falling edge that arrives after the calibration word has been written.
- R7: The write strobe goes low only while chip select is low and the block is driving the data lines. The data lines are driven only during a write cycle.
- R8: Each data-ready falling edge produces one read cycle with chip select and read low. The bus value is captured and presented on the data output, together with a data-valid pulse lasting exactly one cycle.
- R9: The data lines are never driven while read is low. They are released at least one full cycle before read falls.
- R10: A data-ready falling edge that arrives while a write is in progress is not lost. Its read runs after the write finishes.
- R11: Once a control word with bit 3 set has been written, the block drives the shared pin high. A sync request then drives the pin low for exactly SYNC_LOW_CYC cycles, after which it returns high.
- R12: A write that takes the pin out of sync mode waits until any low pulse has ended. The pin is released while it is driven high, so the pin shows no rising edge except the one at the end of each sync pulse.
- R13: Sync requests have no effect while the shared pin is in data-valid mode. The pin stays undriven and no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_standby_i | input | 1 | Requested standby setting |
| cfg_bipolar_i | input | 1 | Requested input range, 1 = bipolar |
| cfg_sync_pin_i | input | 1 | Requested shared-pin mode, 1 = sync input |
| cal_req_i | input | 1 | One-cycle calibration request |
| sync_req_i | input | 1 | One-cycle sync pulse request |
| busy_o | output | 1 | Calibration in progress |
| data_o | output | DW | Last conversion word read |
| data_valid_o | output | 1 | One-cycle pulse when data_o updates |
| adc_cs_n_o | output | 1 | Chip select, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| adc_wr_n_o | output | 1 | Write strobe, active low |
| adc_bus_o | output | DW | Value driven onto the data lines |
| adc_bus_oe_o | output | 1 | Data-line drive enable |
| adc_bus_i | input | DW | Value seen on the data lines |
| adc_drdy_n_i | input | 1 | Converter data-ready, falling edge = new data |
| adc_sync_o | output | 1 | Level driven on the shared pin |
| adc_sync_oe_o | output | 1 | Shared-pin drive enable |

## Verification
The control word is checked against every one of the eight combinations of standby, range and pin mode. Each step in the sweep changes at least one bit, which separates a missing rewrite from a wrong bit position. Reads use all-zeros, all-ones, the two sign-boundary words, two alternating patterns and a walking one across every data line, which exposes swapped, stuck or shifted capture bits. Three further cases pair one event with another: a data-ready edge during a write, a calibration followed by a plain write, and a sync pulse followed at once by leaving sync mode. They show whether a read is dropped, whether the calibration bit is cleared, and whether a spurious edge appears on the shared pin.

// File: rtl/adc_par_pkg.sv
package adc_par_pkg;

   localparam int unsigned CW_STANDBY = 0;
   localparam int unsigned CW_CAL     = 1;
   localparam int unsigned CW_RANGE   = 2;
   localparam int unsigned CW_PINSEL  = 3;
   localparam int unsigned CW_TEST    = 9;
   localparam int unsigned CW_MAXW    = 16;

   typedef struct packed {
      logic pin_sync;
      logic bipolar;
      logic standby;
   } adc_cfg_t;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_WSETUP,
      SQ_WSTROBE,
      SQ_WHOLD,
      SQ_TURN,
      SQ_RSTROBE
   } seq_state_e;

   function automatic logic [CW_MAXW-1:0] pack_ctrl(input adc_cfg_t c, input logic cal);
      logic [CW_MAXW-1:0] w;
      w             = '0;
      w[CW_STANDBY] = c.standby;
      w[CW_CAL]     = cal;
      w[CW_RANGE]   = c.bipolar;
      w[CW_PINSEL]  = c.pin_sync;
      w[CW_TEST]    = 1'b0;
      return w;
   endfunction

endpackage

// File: rtl/adc_drdy_edge.sv
module adc_drdy_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drdy_n_i,
   output logic fall_o
);

   logic lvl;
   logic prev_q;

   generate
      if (STAGES > 0) begin : g_sync
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q[0] <= drdy_n_i;
               for (int i = 1; i < int'(STAGES); i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign lvl = chain_q[STAGES-1];
      end else begin : g_direct
         assign lvl = drdy_n_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl;
   end

   assign fall_o = prev_q & ~lvl;

endmodule

// File: rtl/adc_cfg_track.sv
module adc_cfg_track
   import adc_par_pkg::*;
#(
   parameter int unsigned DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  adc_cfg_t      cfg_i,
   input  logic          cal_req_i,
   input  logic          hold_i,
   input  logic          wr_start_i,
   input  logic          wr_done_i,
   input  logic          drdy_fall_i,
   output logic          wr_pend_o,
   output logic [DW-1:0] word_o,
   output adc_cfg_t      applied_o,
   output logic          busy_o
);

   logic               init_q;
   logic               inflight_q;
   logic               cal_pend_q;
   logic               cal_inflight_q;
   logic               cal_run_q;
   adc_cfg_t           shadow_q;
   adc_cfg_t           applied_q;
   logic [CW_MAXW-1:0] full_word;
   logic               changed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q         <= 1'b1;
         inflight_q     <= 1'b0;
         cal_pend_q     <= 1'b0;
         cal_inflight_q <= 1'b0;
         cal_run_q      <= 1'b0;
         shadow_q       <= '0;
         applied_q      <= '0;
      end else begin
         cal_pend_q <= cal_req_i | (cal_pend_q & ~wr_start_i);
         if (wr_start_i) begin
            init_q         <= 1'b0;
            inflight_q     <= 1'b1;
            shadow_q       <= cfg_i;
            cal_inflight_q <= cal_pend_q;
         end
         if (wr_done_i) begin
            inflight_q     <= 1'b0;
            applied_q      <= shadow_q;
            cal_inflight_q <= 1'b0;
            if (cal_inflight_q) cal_run_q <= 1'b1;
         end else if (drdy_fall_i) begin
            cal_run_q <= 1'b0;
         end
      end
   end

   assign full_word = pack_ctrl(cfg_i, cal_pend_q);
   assign word_o    = full_word[DW-1:0];
   assign changed   = (cfg_i != applied_q);
   assign wr_pend_o = (init_q | cal_pend_q | changed) & ~hold_i & ~inflight_q;
   assign applied_o = applied_q;
   assign busy_o    = cal_pend_q | cal_inflight_q | cal_run_q;

endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
   import adc_par_pkg::*;
#(
   parameter int unsigned DW         = 12,
   parameter int unsigned SETUP_CYC  = 1,
   parameter int unsigned STROBE_CYC = 2,
   parameter int unsigned HOLD_CYC   = 1,
   parameter int unsigned TURN_CYC   = 1,
   parameter int unsigned RD_CYC     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_pend_i,
   input  logic [DW-1:0] word_i,
   input  logic          rd_fall_i,
   input  logic [DW-1:0] bus_i,
   output logic          wr_start_o,
   output logic          wr_done_o,
   output logic          wr_busy_o,
   output logic [DW-1:0] data_o,
   output logic          data_valid_o,
   output logic          cs_n_o,
   output logic          rd_n_o,
   output logic          wr_n_o,
   output logic [DW-1:0] bus_o,
   output logic          bus_oe_o
);

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   localparam int unsigned MAXC = max2(max2(max2(SETUP_CYC, STROBE_CYC), max2(HOLD_CYC, TURN_CYC)), RD_CYC);
   localparam int unsigned CNTW = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam logic [CNTW-1:0] L_SETUP  = CNTW'(SETUP_CYC - 1);
   localparam logic [CNTW-1:0] L_STROBE = CNTW'(STROBE_CYC - 1);
   localparam logic [CNTW-1:0] L_HOLD   = CNTW'(HOLD_CYC - 1);
   localparam logic [CNTW-1:0] L_TURN   = CNTW'(TURN_CYC - 1);
   localparam logic [CNTW-1:0] L_RD     = CNTW'(RD_CYC - 1);

   seq_state_e      state_q, state_d;
   logic [CNTW-1:0] cnt_q, cnt_d;
   logic [DW-1:0]   word_q;
   logic [DW-1:0]   data_q;
   logic            dv_q;
   logic            rd_pend_q;
   logic            cs_n_q, rd_n_q, wr_n_q, oe_q;
   logic            last;
   logic            go_turn;
   logic            capture;

   assign last = (cnt_q == '0);

   always_comb begin
      state_d    = state_q;
      cnt_d      = last ? cnt_q : cnt_q - 1'b1;
      wr_start_o = 1'b0;
      wr_done_o  = 1'b0;
      go_turn    = 1'b0;
      capture    = 1'b0;
      unique case (state_q)
         SQ_IDLE: begin
            if (rd_pend_q) begin
               go_turn = 1'b1;
               state_d = SQ_TURN;
               cnt_d   = L_TURN;
            end else if (wr_pend_i) begin
               wr_start_o = 1'b1;
               state_d    = SQ_WSETUP;
               cnt_d      = L_SETUP;
            end
         end
         SQ_WSETUP: if (last) begin
            state_d = SQ_WSTROBE;
            cnt_d   = L_STROBE;
         end
         SQ_WSTROBE: if (last) begin
            state_d = SQ_WHOLD;
            cnt_d   = L_HOLD;
         end
         SQ_WHOLD: if (last) begin
            wr_done_o = 1'b1;
            state_d   = SQ_IDLE;
         end
         SQ_TURN: if (last) begin
            state_d = SQ_RSTROBE;
            cnt_d   = L_RD;
         end
         SQ_RSTROBE: if (last) begin
            capture = 1'b1;
            state_d = SQ_IDLE;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         cnt_q     <= '0;
         word_q    <= '0;
         data_q    <= '0;
         dv_q      <= 1'b0;
         rd_pend_q <= 1'b0;
         cs_n_q    <= 1'b1;
         rd_n_q    <= 1'b1;
         wr_n_q    <= 1'b1;
         oe_q      <= 1'b0;
      end else begin
         state_q   <= state_d;
         cnt_q     <= cnt_d;
         rd_pend_q <= rd_fall_i | (rd_pend_q & ~go_turn);
         dv_q      <= capture;
         if (wr_start_o) word_q <= word_i;
         if (capture)    data_q <= bus_i;
         cs_n_q <= ~(state_d inside {SQ_WSETUP, SQ_WSTROBE, SQ_WHOLD, SQ_RSTROBE});
         wr_n_q <= ~(state_d == SQ_WSTROBE);
         rd_n_q <= ~(state_d == SQ_RSTROBE);
         oe_q   <= state_d inside {SQ_WSETUP, SQ_WSTROBE, SQ_WHOLD};
      end
   end

   assign wr_busy_o    = (state_q != SQ_IDLE);
   assign data_o       = data_q;
   assign data_valid_o = dv_q;
   assign cs_n_o       = cs_n_q;
   assign rd_n_o       = rd_n_q;
   assign wr_n_o       = wr_n_q;
   assign bus_o        = word_q;
   assign bus_oe_o     = oe_q;

endmodule

// File: rtl/adc_sync_drv.sv
module adc_sync_drv #(
   parameter int unsigned LOW_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_applied_i,
   input  logic mode_req_i,
   input  logic req_i,
   input  logic wr_busy_i,
   input  logic wr_pend_i,
   output logic drv_o,
   output logic oe_o,
   output logic active_o
);

   localparam int unsigned LW = (LOW_CYC < 2) ? 1 : $clog2(LOW_CYC);
   localparam logic [LW-1:0] L_LOW = LW'(LOW_CYC - 1);

   logic          active_q;
   logic [LW-1:0] cnt_q;
   logic          start;

   assign start = req_i & mode_applied_i & mode_req_i & ~wr_busy_i & ~wr_pend_i & ~active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= L_LOW;
      end else if (active_q) begin
         if (cnt_q == '0) active_q <= 1'b0;
         else             cnt_q    <= cnt_q - 1'b1;
      end
   end

   assign drv_o    = ~active_q;
   assign oe_o     = mode_applied_i;
   assign active_o = active_q;

endmodule

// File: rtl/adc_par_ctrl.sv
module adc_par_ctrl
   import adc_par_pkg::*;
#(
   parameter int unsigned DW           = 12,
   parameter int unsigned SETUP_CYC    = 1,
   parameter int unsigned STROBE_CYC   = 2,
   parameter int unsigned HOLD_CYC     = 1,
   parameter int unsigned TURN_CYC     = 1,
   parameter int unsigned RD_CYC       = 2,
   parameter int unsigned SYNC_LOW_CYC = 3,
   parameter int unsigned DRDY_STAGES  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_standby_i,
   input  logic          cfg_bipolar_i,
   input  logic          cfg_sync_pin_i,
   input  logic          cal_req_i,
   input  logic          sync_req_i,
   output logic          busy_o,
   output logic [DW-1:0] data_o,
   output logic          data_valid_o,
   output logic          adc_cs_n_o,
   output logic          adc_rd_n_o,
   output logic          adc_wr_n_o,
   output logic [DW-1:0] adc_bus_o,
   output logic          adc_bus_oe_o,
   input  logic [DW-1:0] adc_bus_i,
   input  logic          adc_drdy_n_i,
   output logic          adc_sync_o,
   output logic          adc_sync_oe_o
);

   generate
      if (DW <= CW_TEST || DW > CW_MAXW) begin : g_bad_width
         $error("adc_par_ctrl: DW must hold the test bit and fit the control word");
      end
      if (SETUP_CYC == 0 || STROBE_CYC == 0 || HOLD_CYC == 0 || TURN_CYC == 0 || RD_CYC == 0) begin : g_bad_timing
         $error("adc_par_ctrl: every strobe phase needs at least one cycle");
      end
      if (SYNC_LOW_CYC == 0) begin : g_bad_sync
         $error("adc_par_ctrl: sync pulse needs at least one cycle");
      end
   endgenerate

   adc_cfg_t      req_cfg;
   adc_cfg_t      applied_cfg;
   logic          drdy_fall;
   logic          wr_pend;
   logic [DW-1:0] word;
   logic          wr_start, wr_done, wr_busy;
   logic          sync_active;

   assign req_cfg.standby  = cfg_standby_i;
   assign req_cfg.bipolar  = cfg_bipolar_i;
   assign req_cfg.pin_sync = cfg_sync_pin_i;

   adc_drdy_edge #(.STAGES(DRDY_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .drdy_n_i (adc_drdy_n_i),
      .fall_o   (drdy_fall)
   );

   adc_cfg_track #(.DW(DW)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_i       (req_cfg),
      .cal_req_i   (cal_req_i),
      .hold_i      (sync_active),
      .wr_start_i  (wr_start),
      .wr_done_i   (wr_done),
      .drdy_fall_i (drdy_fall),
      .wr_pend_o   (wr_pend),
      .word_o      (word),
      .applied_o   (applied_cfg),
      .busy_o      (busy_o)
   );

   adc_bus_seq #(
      .DW(DW), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
      .HOLD_CYC(HOLD_CYC), .TURN_CYC(TURN_CYC), .RD_CYC(RD_CYC)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_pend_i    (wr_pend),
      .word_i       (word),
      .rd_fall_i    (drdy_fall),
      .bus_i        (adc_bus_i),
      .wr_start_o   (wr_start),
      .wr_done_o    (wr_done),
      .wr_busy_o    (wr_busy),
      .data_o       (data_o),
      .data_valid_o (data_valid_o),
      .cs_n_o       (adc_cs_n_o),
      .rd_n_o       (adc_rd_n_o),
      .wr_n_o       (adc_wr_n_o),
      .bus_o        (adc_bus_o),
      .bus_oe_o     (adc_bus_oe_o)
   );

   adc_sync_drv #(.LOW_CYC(SYNC_LOW_CYC)) u_sync (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_applied_i (applied_cfg.pin_sync),
      .mode_req_i     (req_cfg.pin_sync),
      .req_i          (sync_req_i),
      .wr_busy_i      (wr_busy),
      .wr_pend_i      (wr_pend),
      .drv_o          (adc_sync_o),
      .oe_o           (adc_sync_oe_o),
      .active_o       (sync_active)
   );

endmodule

// File: rtl/adc_par_ctrl_chk.sv
module adc_par_ctrl_chk #(
   parameter int unsigned DW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cal_req_i,
   input logic          busy_o,
   input logic          data_valid_o,
   input logic          adc_cs_n_o,
   input logic          adc_rd_n_o,
   input logic          adc_wr_n_o,
   input logic [DW-1:0] adc_bus_o,
   input logic          adc_bus_oe_o,
   input logic          adc_sync_o,
   input logic          adc_sync_oe_o
);

   a_r7_wr_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_wr_n_o |-> (!adc_cs_n_o && adc_bus_oe_o));

   a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rd_n_o |-> !adc_bus_oe_o);

   a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_rd_n_o) |-> !$past(adc_bus_oe_o));

   a_r3_test_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
      adc_bus_oe_o |-> !adc_bus_o[adc_par_pkg::CW_TEST]);

   a_r6_busy_from_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(cal_req_i));

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |=> !data_valid_o);

   a_r12_release_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_sync_oe_o) |-> (adc_sync_o && $past(adc_sync_o)));

   a_r13_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_sync_oe_o |-> adc_sync_o);

endmodule

bind adc_par_ctrl adc_par_ctrl_chk #(.DW(DW)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cal_req_i     (cal_req_i),
   .busy_o        (busy_o),
   .data_valid_o  (data_valid_o),
   .adc_cs_n_o    (adc_cs_n_o),
   .adc_rd_n_o    (adc_rd_n_o),
   .adc_wr_n_o    (adc_wr_n_o),
   .adc_bus_o     (adc_bus_o),
   .adc_bus_oe_o  (adc_bus_oe_o),
   .adc_sync_o    (adc_sync_o),
   .adc_sync_oe_o (adc_sync_oe_o)
);

// File: tb/test_adc_par_ctrl.sv
module test_adc_par_ctrl;

   localparam time CLK_PERIOD = 10ns;
   localparam int  DW         = 12;
   localparam int  SYNC_LOW   = 3;
   localparam int  WDOG_LIMIT = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_standby = 1'b0, cfg_bipolar = 1'b0, cfg_sync_pin = 1'b0;
   logic          cal_req = 1'b0, sync_req = 1'b0;
   logic          busy, data_valid;
   logic [DW-1:0] data;
   logic          cs_n, rd_n, wr_n, bus_oe;
   logic [DW-1:0] bus_out;
   logic [DW-1:0] adc_value = '0;
   logic          drdy_n = 1'b1;
   logic          sync_drv, sync_oe;

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_par_ctrl #(.DW(DW), .SYNC_LOW_CYC(SYNC_LOW)) i_adc_par_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_standby_i(cfg_standby), .cfg_bipolar_i(cfg_bipolar), .cfg_sync_pin_i(cfg_sync_pin),
      .cal_req_i(cal_req), .sync_req_i(sync_req),
      .busy_o(busy), .data_o(data), .data_valid_o(data_valid),
      .adc_cs_n_o(cs_n), .adc_rd_n_o(rd_n), .adc_wr_n_o(wr_n),
      .adc_bus_o(bus_out), .adc_bus_oe_o(bus_oe), .adc_bus_i(adc_value),
      .adc_drdy_n_i(drdy_n), .adc_sync_o(sync_drv), .adc_sync_oe_o(sync_oe)
   );

   // converter model: latch the bus on the rising write strobe
   logic [DW-1:0] latched = '0;
   int            wcnt = 0;
   always @(posedge wr_n) begin
      if (cs_n === 1'b0) begin
         latched = bus_out;
         wcnt++;
      end
   end

   // pin and strobe monitors
   logic pin_prev = 1'b1;
   int   pin_rises = 0, low_run = 0, last_low = 0;
   int   drive_viol = 0, turn_viol = 0, wr_viol = 0;
   logic rd_prev = 1'b1, oe_prev = 1'b0;
   always @(posedge clk) begin
      logic pin_now;
      cycles++;
      if (rst_n) begin
         pin_now = sync_oe ? sync_drv : 1'b1;
         if (!pin_prev && pin_now) pin_rises++;
         pin_prev = pin_now;
         if (sync_oe && !sync_drv) low_run++;
         else if (low_run != 0) begin last_low = low_run; low_run = 0; end
         if (!rd_n && bus_oe) drive_viol++;
         if (rd_prev && !rd_n && oe_prev) turn_viol++;
         if (!wr_n && cs_n) wr_viol++;
         if (bus_oe && !(cs_n == 1'b0)) wr_viol++;
         rd_prev = rd_n;
         oe_prev = bus_oe;
      end
      if (cycles == WDOG_LIMIT) begin
         vectors++; fails++;
         $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wait_write(input int target, input string req);
      for (int k = 0; k < 300 && wcnt < target; k++) @(negedge clk);
      chk(req, wcnt, target);
   endtask

   function automatic logic [DW-1:0] exp_word(input logic st, input logic cal,
                                              input logic bip, input logic pin);
      logic [DW-1:0] w;
      w    = '0;
      w[0] = st; w[1] = cal; w[2] = bip; w[3] = pin;
      return w;
   endfunction

   task automatic read_word(input logic [DW-1:0] v, input string req);
      int got;
      got = 0;
      adc_value = v;
      drdy_n    = 1'b0;
      for (int k = 0; k < 120 && got == 0; k++) begin
         @(negedge clk);
         if (k == 3) drdy_n = 1'b1;
         if (data_valid) got = 1;
      end
      drdy_n = 1'b1;
      chk({req, " valid"}, got, 1);
      chk({req, " data"}, data, v);
      idle(4);
   endtask

   initial begin
      int writes;
      int rises_before;
      idle(3);
      // R1: reset state
      chk("R1 cs_n", cs_n, 1);
      chk("R1 rd_n", rd_n, 1);
      chk("R1 wr_n", wr_n, 1);
      chk("R1 bus_oe", bus_oe, 0);
      chk("R1 busy", busy, 0);
      chk("R1 valid", data_valid, 0);
      chk("R1 sync_oe", sync_oe, 0);
      rst_n = 1'b1;

      // R2: single start-up write
      wait_write(1, "R2 first write");
      chk("R2 word", latched, exp_word(0, 0, 0, 0));
      idle(30);
      chk("R2 no rewrite", wcnt, 1);
      writes = 1;

      // R3 R4 R11: sweep all setting combinations
      for (int c = 1; c <= 8; c++) begin
         logic [2:0] s;
         s = 3'(c % 8);
         cfg_standby  = s[0];
         cfg_bipolar  = s[1];
         cfg_sync_pin = s[2];
         writes++;
         wait_write(writes, "R4 rewrite on change");
         chk("R3 control word", latched, exp_word(s[0], 0, s[1], s[2]));
         idle(3);
         chk("R11 pin drive follows mode", sync_oe, s[2]);
         chk("R11 pin idles high", sync_drv, 1);
      end
      chk("R12 no edge on mode changes", pin_rises, 0);

      // R8: read patterns
      read_word(12'h000, "R8 zeros");
      read_word(12'hFFF, "R8 ones");
      read_word(12'h800, "R8 min neg");
      read_word(12'h7FF, "R8 max pos");
      read_word(12'h555, "R8 alt a");
      read_word(12'hAAA, "R8 alt b");
      for (int b = 0; b < DW; b++) read_word(12'(1 << b), "R8 walking one");

      // R5 R6: calibration
      cal_req = 1'b1;
      @(negedge clk);
      cal_req = 1'b0;
      chk("R6 busy rises", busy, 1);
      writes++;
      wait_write(writes, "R5 cal write");
      chk("R5 cal bit set", latched, exp_word(0, 1, 0, 0));
      idle(20);
      chk("R6 busy held until data", busy, 1);
      read_word(12'h123, "R6 data after cal");
      chk("R6 busy clears", busy, 0);
      cfg_standby = 1'b1;
      writes++;
      wait_write(writes, "R5 next write");
      chk("R5 cal bit cleared", latched, exp_word(1, 0, 0, 0));

      // R10: data-ready during a write
      cfg_bipolar = 1'b1;
      writes++;
      read_word(12'h9C3, "R10 read after write");
      chk("R10 write also done", wcnt, writes);
      chk("R10 word", latched, exp_word(1, 0, 1, 0));

      // R11: sync pulse
      cfg_sync_pin = 1'b1;
      writes++;
      wait_write(writes, "R11 enter sync mode");
      idle(3);
      chk("R11 pin driven", sync_oe, 1);
      sync_req = 1'b1;
      @(negedge clk);
      sync_req = 1'b0;
      idle(SYNC_LOW + 4);
      chk("R11 pulse width", last_low, SYNC_LOW);
      chk("R11 one rising edge", pin_rises, 1);

      // R12: leave sync mode right after a pulse starts
      sync_req = 1'b1;
      @(negedge clk);
      sync_req     = 1'b0;
      cfg_sync_pin = 1'b0;
      writes++;
      wait_write(writes, "R12 leave sync mode");
      idle(3);
      chk("R12 pin released", sync_oe, 0);
      chk("R12 pulse kept full width", last_low, SYNC_LOW);
      chk("R12 only pulse edges", pin_rises, 2);
      chk("R12 word", latched, exp_word(1, 0, 1, 0));

      // R13: sync requests ignored in data-valid mode
      rises_before = pin_rises;
      last_low     = 0;
      sync_req = 1'b1;
      @(negedge clk);
      sync_req = 1'b0;
      idle(SYNC_LOW + 6);
      chk("R13 pin undriven", sync_oe, 0);
      chk("R13 no pulse", last_low, 0);
      chk("R13 no edge", pin_rises, rises_before);

      // R7 R9: strobe monitors over the whole run
      chk("R7 write strobe and drive", wr_viol, 0);
      chk("R9 no drive while reading", drive_viol, 0);
      chk("R9 turnaround", turn_viol, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule